// File: doc/BRIEF.md
# Reference-Clock Tick Prescaler

This block runs on a slow reference clock and turns it into timing strobes for a real-time clock. It makes one strobe per second, and it makes nine binary sub-second strobes at 2, 4, 8, 16, 32, 64, 128, 256 and 512 Hz. The reference may run at 32768 Hz, 32000 Hz or 38400 Hz. A 2-bit select field in an 8-bit control word tells the block which of these rates is present. An enable bit in the same word starts and stops all counting. Each strobe is high for exactly one reference cycle. The strobes feed a timekeeping core and an interrupt-status block in the same clock domain.

The block cannot use a simple binary ripple divider, because two of the three reference rates are not powers of two. Instead, a fractional accumulator first makes an exact 1024 Hz base strobe from whichever rate is selected. A 10-bit counter then halves the base strobe, and each tap fires when its group of low counter bits is all ones. The average rate of every output is exact over the long term. For the non-binary references, the spacing between strobes varies by one reference cycle from one period to the next.

Control is a plain register port and has no handshake. A write takes effect at the clock edge where `ctl_we` is high. From that edge on, the register reads back the stored enable and select values.

Top module: `rtc_tick_prescaler`

## Requirements
- R1: While `rst_n` is low, and after it is released, `ctl_rdata` reads 0x00 and every tick output is low. The block therefore starts disabled, with select code 0.
- R2: `ctl_rdata` returns the enable bit in bit 7 and the select code in bits 6:5, both from the last write. Bits 4:0 always read zero, whatever value was written to them.
- R3: While the enable bit is 0, no tick is produced and the divider state is held at zero. Enabling the block again therefore starts a fresh phase.
- R4: A write that sets the enable bit while it is 0 restarts the phase. So does a write that changes the select code while the block is enabled. Call the edge of that write cycle 0, and let M be the selected reference rate. The n-th tick of a rate-f output is then high in cycle ceil(n*M/f)+1. `tick_sec` has f = 1, and `tick_bin[i]` has f = 2^(i+1). Select code 0 gives M = 32768.
- R5: Select code 1 gives M = 32000, with the timing of R4.
- R6: Select code 2 gives M = 38400, with the timing of R4.
- R7: Select code 3 gives the same rates and phases as code 0. Because the raw code differs, switching between code 0 and code 3 while enabled still restarts the phase.
- R8: Every tick output is high for a single cycle and is low in the cycle that follows.
- R9: Writing the same enable and select values that are already stored leaves the phase untouched, and the ticks continue without a gap. A write that changes the select code restarts the phase at the write edge, so no shortened period is produced.
- R10: Whenever a slower output fires, every faster binary output fires in the same cycle. For example, `tick_sec` high implies `tick_bin[8]` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock (32768, 32000 or 38400 Hz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control write data: bit 7 enable, bits 6:5 select |
| ctl_rdata | output | 8 | Control read-back |
| tick_sec | output | 1 | One-cycle strobe at 1 Hz |
| tick_bin | output | 9 | One-cycle strobes; bit i at 2^(i+1) Hz |

## Verification
The embedded properties assume the following about the inputs:
- `ctl_wdata` carries a fully defined value in every cycle in which `ctl_we` is high.
- The base rate is less than half of every reference rate, so two base strobes can never fall in adjacent cycles. The default parameters satisfy this.

The bench drives the inputs as follows:
- It changes its inputs only on the falling edge of the clock.
- Every control word it writes is fully defined.
- The random words mix the enable bit, all four select codes and junk in bits 4:0.
- The run lengths are long enough for the 1 Hz output to fire at least once for every reference rate.
- A reference model compares every output on every cycle.

// File: rtl/rtc_pre_pkg.sv
package rtc_pre_pkg;
  localparam int unsigned CTL_W   = 8;
  localparam int unsigned EN_BIT  = 7;
  localparam int unsigned SEL_LSB = 5;
  localparam int unsigned SEL_W   = 2;

  typedef logic [SEL_W-1:0] ref_sel_t;

  typedef struct packed {
    logic     en;
    ref_sel_t sel;
  } pre_ctl_t;
endpackage

// File: rtl/rtc_pre_ctrl.sv
module rtc_pre_ctrl
  import rtc_pre_pkg::*;
(
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  output pre_ctl_t         ctl_o,
  output logic             chain_clr_o
);
  pre_ctl_t ctl_q;
  pre_ctl_t ctl_w;
  logic     unused_low_bits;

  assign ctl_w = '{en: ctl_wdata[EN_BIT], sel: ctl_wdata[SEL_LSB +: SEL_W]};
  assign unused_low_bits = ^ctl_wdata[SEL_LSB-1:0];

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_w;
  end

  // Clear the chain while idle, on a disable write, or when the select changes.
  always_comb begin
    chain_clr_o = !ctl_q.en;
    if (ctl_we && (!ctl_w.en || (ctl_w.sel != ctl_q.sel))) chain_clr_o = 1'b1;
    ctl_rdata = '0;
    ctl_rdata[EN_BIT] = ctl_q.en;
    ctl_rdata[SEL_LSB +: SEL_W] = ctl_q.sel;
  end

  assign ctl_o = ctl_q;

  // R2
  ctl_readback_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ctl_we |=> (ctl_rdata[EN_BIT] == $past(ctl_wdata[EN_BIT])));

  // R2
  ctl_low_zero_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ctl_rdata[SEL_LSB-1:0] == '0);
endmodule

// File: rtl/rtc_pre_frac.sv
module rtc_pre_frac
  import rtc_pre_pkg::*;
#(
  parameter int unsigned REF0_HZ = 32768,
  parameter int unsigned REF1_HZ = 32000,
  parameter int unsigned REF2_HZ = 38400,
  parameter int unsigned BASE_HZ = 1024
) (
  input  logic     clk_ref,
  input  logic     rst_n,
  input  logic     clr_i,
  input  ref_sel_t sel_i,
  output logic     base_stb_o
);
  localparam int unsigned MAX01  = (REF0_HZ > REF1_HZ) ? REF0_HZ : REF1_HZ;
  localparam int unsigned MAX_HZ = (MAX01 > REF2_HZ) ? MAX01 : REF2_HZ;
  localparam int unsigned ACC_W  = $clog2(MAX_HZ + BASE_HZ + 1);

  logic [ACC_W-1:0] modulus;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_sum;
  logic             wrap;

  // Code 3 is reserved and falls back to the first reference.
  always_comb begin
    unique case (sel_i)
      2'd1:    modulus = ACC_W'(REF1_HZ);
      2'd2:    modulus = ACC_W'(REF2_HZ);
      default: modulus = ACC_W'(REF0_HZ);
    endcase
    acc_sum = acc_q + ACC_W'(BASE_HZ);
    wrap    = (acc_sum >= modulus);
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= '0;
      base_stb_o <= 1'b0;
    end else if (clr_i) begin
      acc_q      <= '0;
      base_stb_o <= 1'b0;
    end else begin
      base_stb_o <= wrap;
      acc_q      <= wrap ? (acc_sum - modulus) : acc_sum;
    end
  end

  // R4
  acc_in_range_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    acc_q < modulus);

  // R8
  base_single_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    base_stb_o |=> !base_stb_o);

  // R9
  clr_zeroes_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    clr_i |=> (!base_stb_o && (acc_q == '0)));
endmodule

// File: rtl/rtc_pre_halver.sv
module rtc_pre_halver #(
  parameter int unsigned BASE_HZ = 1024,
  parameter int unsigned N_TAPS  = 9
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              base_stb_i,
  output logic              tick_sec_o,
  output logic [N_TAPS-1:0] tick_bin_o
);
  localparam int unsigned CNT_W = $clog2(BASE_HZ);

  logic [CNT_W-1:0]  cnt_q;
  logic [N_TAPS-1:0] hit;
  logic              hit_sec;

  // Tap i runs at 2^(i+1) Hz and needs its low CNT_W-1-i counter bits all ones.
  for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
    localparam int unsigned LOW = CNT_W - 1 - i;
    assign hit[i] = &cnt_q[LOW-1:0];
  end
  assign hit_sec = &cnt_q;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      tick_bin_o <= '0;
      tick_sec_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q      <= '0;
      tick_bin_o <= '0;
      tick_sec_o <= 1'b0;
    end else if (base_stb_i) begin
      cnt_q      <= cnt_q + CNT_W'(1);
      tick_bin_o <= hit;
      tick_sec_o <= hit_sec;
    end else begin
      tick_bin_o <= '0;
      tick_sec_o <= 1'b0;
    end
  end

  // R10
  sec_nest_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    tick_sec_o |-> tick_bin_o[N_TAPS-1]);

  for (genvar i = 0; i + 1 < N_TAPS; i++) begin : g_nest
    // R10
    tap_nest_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      tick_bin_o[i] |-> tick_bin_o[i+1]);
  end

  // R8
  tick_single_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (tick_sec_o || (|tick_bin_o)) |=> (!tick_sec_o && (tick_bin_o == '0)));
endmodule

// File: rtl/rtc_tick_prescaler.sv
module rtc_tick_prescaler
  import rtc_pre_pkg::*;
#(
  parameter int unsigned REF0_HZ = 32768,
  parameter int unsigned REF1_HZ = 32000,
  parameter int unsigned REF2_HZ = 38400,
  parameter int unsigned BASE_HZ = 1024,
  localparam int unsigned N_TAPS = $clog2(BASE_HZ) - 1
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  output logic              tick_sec,
  output logic [N_TAPS-1:0] tick_bin
);
  pre_ctl_t ctl;
  logic     chain_clr;
  logic     base_stb;

  rtc_pre_ctrl u_ctrl (
    .clk_ref     (clk_ref),
    .rst_n       (rst_n),
    .ctl_we      (ctl_we),
    .ctl_wdata   (ctl_wdata),
    .ctl_rdata   (ctl_rdata),
    .ctl_o       (ctl),
    .chain_clr_o (chain_clr)
  );

  rtc_pre_frac #(
    .REF0_HZ (REF0_HZ),
    .REF1_HZ (REF1_HZ),
    .REF2_HZ (REF2_HZ),
    .BASE_HZ (BASE_HZ)
  ) u_frac (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .clr_i      (chain_clr),
    .sel_i      (ctl.sel),
    .base_stb_o (base_stb)
  );

  rtc_pre_halver #(
    .BASE_HZ (BASE_HZ),
    .N_TAPS  (N_TAPS)
  ) u_halver (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .clr_i      (chain_clr),
    .base_stb_i (base_stb),
    .tick_sec_o (tick_sec),
    .tick_bin_o (tick_bin)
  );

  // R3
  idle_quiet_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !ctl.en |-> (!tick_sec && (tick_bin == '0)));
endmodule

// File: tb/rtc_tick_prescaler_tb_top.sv
`timescale 1ns/1ps
module rtc_tick_prescaler_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic       tick_sec;
  logic [8:0] tick_bin;

  int unsigned checks = 0;
  int unsigned failures = 0;

  logic       m_on = 1'b0;
  logic [1:0] m_sel = 2'd0;
  longint     m_k = 0;

  always #4 clk = ~clk;

  rtc_tick_prescaler dut_i (
    .clk_ref   (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .ctl_rdata (ctl_rdata),
    .tick_sec  (tick_sec),
    .tick_bin  (tick_bin)
  );

  function automatic longint ref_mod(input logic [1:0] s);
    case (s)
      2'd1:    return 32000;
      2'd2:    return 38400;
      default: return 32768;
    endcase
  endfunction

  // n-th tick of rate f lands in cycle ceil(n*M/f)+1 after the restart edge.
  function automatic logic exp_tick(input longint k, input longint f, input longint m);
    if (k < 2) return 1'b0;
    return (((k - 1) * f) / m) > (((k - 2) * f) / m);
  endfunction

  function automatic string tag_of(input logic on, input logic [1:0] s);
    if (!on) return "R3";
    case (s)
      2'd0:    return "R4";
      2'd1:    return "R5";
      2'd2:    return "R6";
      default: return "R7";
    endcase
  endfunction

  // Per-cycle compare. The exact-cycle model also covers single-cycle
  // width (R8) and nesting of rates (R10).
  task automatic check_cycle();
    logic [9:0] exp_v;
    logic [7:0] exp_rd;
    exp_v = '0;
    if (m_on) begin
      exp_v[9] = exp_tick(m_k, 1, ref_mod(m_sel));
      for (int i = 0; i < 9; i++) exp_v[i] = exp_tick(m_k, longint'(2) << i, ref_mod(m_sel));
    end
    checks++;
    if ({tick_sec, tick_bin} !== exp_v) begin
      failures++;
      $display("FAIL %s k=%0d ticks act=%b exp=%b", tag_of(m_on, m_sel), m_k, {tick_sec, tick_bin}, exp_v);
    end
    exp_rd = {m_on, m_sel, 5'b0};
    checks++;
    if (ctl_rdata !== exp_rd) begin
      failures++;
      $display("FAIL R2 rdata act=%h exp=%h", ctl_rdata, exp_rd);
    end
  endtask

  // Called at a falling edge; applies inputs, advances one clock, checks.
  task automatic cyc(input logic we, input logic [7:0] wd);
    ctl_we = we;
    ctl_wdata = wd;
    @(posedge clk);
    if (we) begin
      if (!wd[7]) begin
        m_on = 1'b0;
        m_k = 0;
      end else if (!m_on || (wd[6:5] != m_sel)) begin
        m_on = 1'b1;
        m_k = 0;
      end else begin
        m_k++;
      end
      m_sel = wd[6:5];
    end else if (m_on) begin
      m_k++;
    end
    @(negedge clk);
    ctl_we = 1'b0;
    check_cycle();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00);
  endtask

  task automatic finish_up();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=running exp=finished");
    finish_up();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: state during and after reset
    checks++;
    if ({tick_sec, tick_bin} !== 10'b0 || ctl_rdata !== 8'h00) begin
      failures++;
      $display("FAIL R1 in reset act=%b/%h exp=0/00", {tick_sec, tick_bin}, ctl_rdata);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check_cycle();

    // R3: disabled with assorted select codes, no ticks
    cyc(1'b1, 8'h40);
    run(150);
    cyc(1'b1, 8'h3F);
    run(150);

    // R4 and R2: code 0, junk in low bits reads back as zero
    cyc(1'b1, 8'h9F);
    run(33000);
    // R5: select change while enabled restarts the phase (R9)
    cyc(1'b1, 8'hA0);
    run(700);
    // R9: identical rewrite keeps the phase
    cyc(1'b1, 8'hA5);
    run(31600);
    // R6
    cyc(1'b1, 8'hC0);
    run(38700);
    // R7: reserved code acts like code 0
    cyc(1'b1, 8'hE0);
    run(2100);
    // R3: disable, then re-enable starts fresh
    cyc(1'b1, 8'h60);
    run(200);
    cyc(1'b1, 8'hE0);
    run(300);

    // Random mix of enable, select and junk bits
    for (int it = 0; it < 150; it++) begin
      logic [31:0] r;
      int len;
      r = $urandom;
      len = 1 + int'($urandom % 256);
      cyc(1'b1, {(r[1:0] != 2'b00), r[3:2], r[8:4]});
      run(len - 1);
    end
    finish_up();
  end
endmodule